// File: doc/BRIEF.md
# Asynchronous Host Bus Interface

This block sits between an asynchronous CPU bus and the internal side of a display controller. The CPU reaches the controller through two separately selected windows. One is a small register window of 16 bytes, where only the lowest address bits matter. The other maps the video memory directly into the CPU's address space. The host may run the bus 16 bits wide, with one write strobe per byte lane, or 8 bits wide. In 8-bit mode the upper-lane strobe pin carries address bit 0 instead of a strobe.

Chip selects and strobes are brought into the internal clock domain through two-flop synchronisers. Each strobe assertion launches exactly one request on a request/acknowledge port. That request carries the window, a byte address, byte enables and write data. The request is held until the internal side acknowledges it. A three-state, active-low ready line tells the CPU when the access is done. The data bus is driven only while a read is selected.

Top module: `host_bus_bridge`

## Requirements
- R1: After reset, `req` is 0. With both chip selects high, `rdy_oe` and `dout_oe` are 0.
- R2: `rdy_oe` is 1 exactly while `cs_io_n` or `cs_mem_n` is low. When it is 0, the ready line is high impedance.
- R3: `dout_oe` is 1 exactly while `rd_n` is low and at least one chip select is low.
- R4: While a chip select is low and no strobe is low, `rdy_n` is 1. In 16-bit mode the strobes are `rd_n`, `wr_lo_n` and `wr_hi_n`. In 8-bit mode they are `rd_n` and `wr_lo_n`.
- R5: `rdy_n` goes to 0 only after the internal `ack` for the access. It stays 0 while the strobe is held, and it returns to 1 as soon as the strobe is released.
- R6: One strobe assertion produces exactly one request, however long the strobe is held. `req` and its fields stay steady until `ack`, and `req` drops in the cycle after `ack`.
- R7: In a register-window access, `req_space` is 0, and `req_addr` holds only the low 4 byte-address bits. Address bits 20..4 are ignored and read as zero.
- R8: In a memory-window access, `req_space` is 1, and `req_addr` is {`addr[20:1]`, bit 0}. Bit 0 is 0 in 16-bit mode.
- R9: In a 16-bit write, `req_be[1]` is set when `wr_hi_n` is low and `req_be[0]` is set when `wr_lo_n` is low. `req_wdata` is `din`.
- R10: In 8-bit mode (`mode16`=0), the level on `wr_hi_n` is address bit 0 and is not a strobe. `req_be` is 2'b10 when that bit is 1 and 2'b01 when it is 0. `req_wdata` is {`din[7:0]`, `din[7:0]`}.
- R11: A read returns `ack_rdata` on `dout` in 16-bit mode. In 8-bit mode `dout` is {8'h00, selected byte}, where the upper byte is selected when address bit 0 is 1.
- R12: If both chip selects are low, the access goes to the register window (`req_space`=0).
- R13: No request is made when a chip select is low without a strobe, or when a strobe is low without a chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset |
| mode16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cs_io_n | input | 1 | Register window select, active low |
| cs_mem_n | input | 1 | Memory window select, active low |
| wr_hi_n | input | 1 | Upper byte write strobe (16-bit) or address bit 0 (8-bit) |
| wr_lo_n | input | 1 | Lower byte write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | 20 | CPU address bits 20..1 |
| din | input | 16 | Data from the CPU |
| dout | output | 16 | Data to the CPU |
| dout_oe | output | 1 | Data bus output enable |
| rdy_n | output | 1 | Ready value, active low |
| rdy_oe | output | 1 | Ready output enable |
| req | output | 1 | Internal request, held until ack |
| req_we | output | 1 | 1 = write, 0 = read |
| req_space | output | 1 | 0 = register window, 1 = memory window |
| req_addr | output | 21 | Byte address of the access |
| req_be | output | 2 | Byte enables, bit 1 = upper lane |
| req_wdata | output | 16 | Write data |
| ack | input | 1 | Internal acknowledge, one cycle |
| ack_rdata | input | 16 | Read data, valid with ack |

## Verification
The hardest case to reach from the ports is a strobe held long after the acknowledge. In that case the block must neither launch a second request nor release ready early. The stimulus holds a strobe twenty cycles past the acknowledge and counts requests. It also checks that ready stays asserted and then drops at once when the strobe is released.

The second hard case is 8-bit mode with `wr_hi_n` low while no other strobe is active. The pin looks like a strobe there, but it must be taken as an address bit. The stimulus holds this condition for many cycles under an active chip select and checks that no request appears and ready stays high.

// File: rtl/host_bus_bridge.sv
module host_bus_bridge #(
  parameter int AW = 21,
  parameter int IOW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode16,
  input  logic          cs_io_n,
  input  logic          cs_mem_n,
  input  logic          wr_hi_n,
  input  logic          wr_lo_n,
  input  logic          rd_n,
  input  logic [AW-1:1] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          rdy_n,
  output logic          rdy_oe,
  output logic          req,
  output logic          req_we,
  output logic          req_space,
  output logic [AW-1:0] req_addr,
  output logic [1:0]    req_be,
  output logic [DW-1:0] req_wdata,
  input  logic          ack,
  input  logic [DW-1:0] ack_rdata
);
  localparam int HB = DW / 2;

  typedef enum logic [1:0] {IDLE, BUSY, DONE} st_t;
  st_t st;

  logic [4:0] s1, s2;
  logic acc_q, a0_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
    end else begin
      s1 <= {cs_io_n, cs_mem_n, wr_hi_n, wr_lo_n, rd_n};
      s2 <= s1;
    end

  wire io_s  = ~s2[4];
  wire mem_s = ~s2[3];
  wire whi_s = ~s2[2] & mode16;
  wire wlo_s = ~s2[1];
  wire rd_s  = ~s2[0];
  wire wr_s  = whi_s | wlo_s;
  wire acc_s = (io_s | mem_s) & (wr_s | rd_s);

  wire a0 = mode16 ? 1'b0 : wr_hi_n;
  wire raw_strobe = ~rd_n | ~wr_lo_n | (mode16 & ~wr_hi_n);

  assign rdy_oe  = ~cs_io_n | ~cs_mem_n;
  assign dout_oe = ~rd_n & rdy_oe;
  assign rdy_n   = ~(rdy_oe & raw_strobe & (st == DONE));
  assign req     = (st == BUSY);

  logic [1:0] be_n;
  always_comb begin
    if (mode16) be_n = wr_s ? {whi_s, wlo_s} : 2'b11;
    else        be_n = a0 ? 2'b10 : 2'b01;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= IDLE;
      acc_q     <= 1'b0;
      a0_q      <= 1'b0;
      req_we    <= 1'b0;
      req_space <= 1'b0;
      req_addr  <= '0;
      req_be    <= '0;
      req_wdata <= '0;
      dout      <= '0;
    end else begin
      acc_q <= acc_s;
      case (st)
        IDLE: if (acc_s && !acc_q) begin
          st        <= BUSY;
          a0_q      <= a0;
          req_we    <= wr_s;
          req_space <= ~io_s;
          req_addr  <= io_s ? AW'({addr[IOW-1:1], a0}) : {addr, a0};
          req_be    <= be_n;
          req_wdata <= mode16 ? din : {din[HB-1:0], din[HB-1:0]};
        end
        BUSY: if (ack) begin
          st   <= DONE;
          dout <= mode16 ? ack_rdata
                : {{HB{1'b0}}, (a0_q ? ack_rdata[DW-1:HB] : ack_rdata[HB-1:0])};
        end
        DONE: if (!acc_s) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
endmodule

module host_bus_bridge_chk #(
  parameter int AW = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_n,
  input logic          rdy_n,
  input logic          rdy_oe,
  input logic          dout_oe,
  input logic          req,
  input logic          ack,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_be
);
  AST_READY_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n) !rdy_n |-> rdy_oe); // R2
  AST_DOUT_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n) dout_oe |-> !rd_n); // R3
  AST_NO_READY_AT_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n) $rose(req) |-> rdy_n); // R5
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) req && !ack |=> req); // R6
  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n) req && ack |=> !req); // R6
  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n) req && !ack |=> $stable(req_addr) && $stable(req_be)); // R6
endmodule

bind host_bus_bridge host_bus_bridge_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .rdy_n(rdy_n), .rdy_oe(rdy_oe),
  .dout_oe(dout_oe), .req(req), .ack(ack), .req_addr(req_addr), .req_be(req_be)
);

// File: tb/host_bus_bridge_test.sv
module host_bus_bridge_test;
  logic clk = 0, rst_n = 0, mode16 = 1;
  logic cs_io_n = 1, cs_mem_n = 1, wr_hi_n = 1, wr_lo_n = 1, rd_n = 1;
  logic [20:1] addr = '0;
  logic [15:0] din = '0, dout, req_wdata, ack_rdata;
  logic dout_oe, rdy_n, rdy_oe, req, req_we, req_space, ack = 0;
  logic [20:0] req_addr;
  logic [1:0] req_be;

  always #5 clk = ~clk;

  host_bus_bridge uut (.*);

  int total = 0, bad = 0, nreq = 0, lat = 2, cnt = 0;
  logic [15:0] resp = 16'h0;
  logic g_we, g_space; logic [20:0] g_addr; logic [1:0] g_be; logic [15:0] g_wdata;
  logic [15:0] rd_val;

  assign ack_rdata = resp;

  always @(posedge clk) begin
    ack <= 1'b0;
    if (req && !ack) begin
      if (cnt >= lat) begin
        ack <= 1'b1; cnt <= 0; nreq <= nreq + 1;
        g_we <= req_we; g_space <= req_space; g_addr <= req_addr;
        g_be <= req_be; g_wdata <= req_wdata;
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // every-clock reference: output enables and idle ready from pin levels
  always @(negedge clk) if (rst_n) begin
    automatic bit csa = !cs_io_n || !cs_mem_n;
    automatic bit stb = !rd_n || !wr_lo_n || (mode16 && !wr_hi_n);
    chk("R2 rdy_oe", rdy_oe, csa);
    chk("R3 dout_oe", dout_oe, csa && !rd_n);
    if (csa && !stb) chk("R4 idle ready high", rdy_n, 1);
  end

  // whi/wlo/rdl: 1 = pull that pin low; hold: cycles held after ready
  task automatic access(input bit cio, input bit cmem, input bit whi, input bit wlo,
                        input bit rdl, input logic [20:1] a, input logic [15:0] d,
                        input int hold, input bit expect_req, input string tag);
    int n0 = nreq;
    bit got = 0;
    @(negedge clk);
    cs_io_n = !cio; cs_mem_n = !cmem; addr = a; din = d;
    if (!mode16) wr_hi_n = !whi;
    @(negedge clk);
    if (mode16) wr_hi_n = !whi;
    wr_lo_n = !wlo; rd_n = !rdl;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!rdy_n) begin got = 1; break; end
    end
    chk({tag, " ready seen"}, got, expect_req);
    if (got) begin
      chk("R5 ready only after ack", nreq > n0, 1);
      rd_val = dout;
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk("R5 ready held", rdy_n, 0);
      end
    end
    wr_hi_n = mode16 ? 1'b1 : wr_hi_n; wr_lo_n = 1; rd_n = 1;
    #1;
    if (got) chk("R5 ready released", rdy_n, (cio || cmem) && !mode16 && !wr_hi_n ? 1 : 1);
    repeat (5) @(negedge clk);
    cs_io_n = 1; cs_mem_n = 1; wr_hi_n = 1;
    repeat (3) @(negedge clk);
    chk({tag, " R6 request count"}, nreq - n0, expect_req ? 1 : 0);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 req", req, 0);
    chk("R1 rdy_oe", rdy_oe, 0);
    chk("R1 dout_oe", dout_oe, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    access(1, 0, 1, 1, 0, 20'hABCD3, 16'hC0DE, 3, 1, "R7");
    chk("R7 space", g_space, 0); chk("R7 addr", g_addr, 21'h6);
    chk("R9 we", g_we, 1); chk("R9 be", g_be, 2'b11); chk("R9 wdata", g_wdata, 16'hC0DE);

    access(1, 0, 1, 0, 0, 20'h00005, 16'h1357, 3, 1, "R9");
    chk("R9 upper be", g_be, 2'b10); chk("R7 addr", g_addr, 21'hA);

    lat = 5;
    access(0, 1, 0, 1, 0, 20'h8F0F1, 16'h2468, 3, 1, "R8");
    chk("R8 space", g_space, 1); chk("R8 addr", g_addr, {20'h8F0F1, 1'b0});
    chk("R9 lower be", g_be, 2'b01);

    resp = 16'hBEEF;
    access(0, 1, 0, 0, 1, 20'h12345, 16'h0, 3, 1, "R11");
    chk("R11 read data", rd_val, 16'hBEEF); chk("R11 we", g_we, 0);
    chk("R11 be", g_be, 2'b11);

    lat = 1;
    access(1, 1, 0, 1, 0, 20'hFFFF7, 16'h1111, 2, 1, "R12");
    chk("R12 io priority", g_space, 0); chk("R12 addr", g_addr, 21'hE);

    access(1, 0, 0, 0, 0, 20'h1, 16'h0, 0, 0, "R13 cs no strobe");
    access(0, 0, 1, 1, 1, 20'h1, 16'h0, 0, 0, "R13 strobe no cs");
    chk("R13 rdy_oe without cs", rdy_oe, 0);

    access(0, 1, 0, 1, 0, 20'h00100, 16'h9999, 20, 1, "R6 long hold");

    mode16 = 0;
    // 8-bit: whi=0 leaves wr_hi_n high => address bit 0 = 1
    access(0, 1, 0, 1, 0, 20'h00042, 16'hFF5A, 2, 1, "R10");
    chk("R10 addr", g_addr, {20'h00042, 1'b1}); chk("R10 be", g_be, 2'b10);
    chk("R10 wdata", g_wdata, 16'h5A5A);

    access(1, 0, 1, 1, 0, 20'h00003, 16'h00A5, 2, 1, "R10");
    chk("R10 a0=0 addr", g_addr, 21'h6); chk("R10 a0=0 be", g_be, 2'b01);

    resp = 16'h1234;
    access(0, 1, 1, 0, 1, 20'h00010, 16'h0, 2, 1, "R11");
    chk("R11 8-bit low byte", rd_val, 16'h0034);
    access(0, 1, 0, 0, 1, 20'h00010, 16'h0, 2, 1, "R11");
    chk("R11 8-bit high byte", rd_val, 16'h0012);

    // wr_hi_n low alone in 8-bit mode is an address level, not a strobe
    access(1, 0, 1, 0, 0, 20'h00001, 16'h0, 0, 0, "R10 no strobe");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule